// File: doc/BRIEF.md
# Page Access Permission and Protection-Key Checker

This block makes the final permission decision for a memory access once a page-table walk has produced a leaf. It receives the leaf's combined user, writable and no-execute attributes and its 4-bit protection key. It also receives two pre-decoded walk outcomes: leaf missing and reserved bit set. From the requester it takes the access type and the privilege level. It also receives the paging control flags: write-protect, supervisor read prevention, supervisor execute prevention, no-execute enable, user key enable and supervisor key enable. It receives two key-rights registers as well, one for user pages and one for supervisor pages.

The decision has two layers. The page attributes first give a base read/write/execute set. A per-key access-disable or write-disable pair then narrows that set. The result is either a permission vector or a fault with a page-fault error code. The outputs are registered, so they appear one cycle after an input strobe, together with an output-valid pulse. Outputs hold their values between strobes.

Top module: `pkey_perm_check`

## Requirements
- R1: Outputs are registered. After reset, valid_o, fault_o, perm_o and err_code_o are all zero. One clock after valid_i is high, valid_o is high and carries the decision for the inputs of that cycle. When valid_i is low, valid_o goes low on the next clock and the other outputs keep their values.
- R2: A leaf that is not present (leaf_present_i low) always faults. Its error code has P (bit 0) clear, and only the W, U and I/D bits may be set.
- R3: A present leaf with leaf_rsvd_i high faults with RSVD (bit 3) set and P clear.
- R4: A user-mode access to a present, non-reserved leaf without the user attribute faults as a protection violation with P (bit 0) set.
- R5: Read is granted unless the access is supervisor-mode, smap_i is set and the leaf is a user page. When read is granted, write is granted if the leaf is writable, or if the access is supervisor-mode and wp_i is clear.
- R6: Execute is granted when the no-execute attribute is clear, and either the access is user-mode or it is not the case that smep_i is set and the leaf is a user page.
- R7: User pages take key rights from ukey_rights_i only when ukey_en_i is set. Supervisor pages take key rights from skey_rights_i only when skey_en_i is set. Otherwise, and also when the selected register is zero, the key imposes no restriction.
- R8: For key k, rights bit 2k (access-disable) removes read and write. Rights bit 2k+1 (write-disable) removes write only, and only for a user-mode access or when wp_i is set.
- R9: A key never removes execute permission, so a fetch never takes a key fault. When the key rights deny the requested access, the fault sets PK (bit 5) and P (bit 0). This takes precedence over a base-permission denial.
- R10: On every fault, the error code sets W (bit 1) for a store and U (bit 2) for a user-mode access. It sets I/D (bit 4) for a fetch only when nxe_i or smep_i is set.
- R11: Access type encoding is load=0, store=1, fetch=2. perm_o is {execute, write, read} at bits {2,1,0}. The requested type is checked against perm_o bit (1 << type). A grant returns the final permission set with fault_o low and err_code_o zero. A fault returns perm_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| user_mode_i | input | 1 | Access made at user privilege |
| acc_type_i | input | 2 | 0 load, 1 store, 2 fetch |
| leaf_present_i | input | 1 | Leaf entry present |
| leaf_rsvd_i | input | 1 | Walk found a reserved bit set |
| leaf_user_i | input | 1 | Combined user attribute |
| leaf_write_i | input | 1 | Combined writable attribute |
| leaf_nx_i | input | 1 | Combined no-execute attribute |
| leaf_key_i | input | 4 | Protection key of the leaf |
| wp_i | input | 1 | Supervisor write-protect enable |
| smap_i | input | 1 | Supervisor read-of-user-page prevention |
| smep_i | input | 1 | Supervisor execute-of-user-page prevention |
| nxe_i | input | 1 | No-execute enable |
| ukey_en_i | input | 1 | Key checks on user pages |
| skey_en_i | input | 1 | Key checks on supervisor pages |
| ukey_rights_i | input | 32 | Rights pairs for user pages |
| skey_rights_i | input | 32 | Rights pairs for supervisor pages |
| valid_o | output | 1 | Decision valid |
| perm_o | output | 3 | Granted {execute, write, read} |
| fault_o | output | 1 | Access faults |
| err_code_o | output | 6 | Page-fault error code |

## Verification
A key denial and a base-permission denial can both apply to the same access. The case that exposes this is a user-mode store to a read-only user page whose key also has write-disable set while key checks are on. Both checks reject the write, and the error code must show the key fault (PK, P, W and U, value 0x27), not a plain protection fault. A related overlap is a fetch from a page whose key has access-disable set. The base and key layers act in the same cycle, and the result must be execute-only with no fault. The bench's model decides the precedence independently, and it drives these collisions both directly and through random mixes with biased key registers.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    FK_NONE,
    FK_ABSENT,
    FK_RSVD,
    FK_PROT,
    FK_KEY
  } fault_e;

  localparam int PRM_BITS = 3;
  localparam int PRM_R    = 0;
  localparam int PRM_W    = 1;
  localparam int PRM_X    = 2;

  localparam int EC_BITS = 6;
  localparam int EC_P    = 0;
  localparam int EC_W    = 1;
  localparam int EC_U    = 2;
  localparam int EC_RSVD = 3;
  localparam int EC_ID   = 4;
  localparam int EC_PK   = 5;
endpackage

// File: rtl/pkc_base_perm.sv
module pkc_base_perm
  import pkc_pkg::*;
(
  input  logic                user_i,
  input  logic                pg_user_i,
  input  logic                pg_write_i,
  input  logic                pg_nx_i,
  input  logic                wp_i,
  input  logic                smap_i,
  input  logic                smep_i,
  output logic [PRM_BITS-1:0] perm_o
);
  logic rd_ok;

  always_comb begin
    rd_ok          = !(smap_i && !user_i && pg_user_i);
    perm_o         = '0;
    perm_o[PRM_R]  = rd_ok;
    perm_o[PRM_W]  = rd_ok && (pg_write_i || (!user_i && !wp_i));
    perm_o[PRM_X]  = !pg_nx_i && (user_i || !(smep_i && pg_user_i));
  end
endmodule

// File: rtl/pkc_key_gate.sv
module pkc_key_gate
  import pkc_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
  input  logic                user_i,
  input  logic                pg_user_i,
  input  logic [KEY_W-1:0]    key_i,
  input  logic                wp_i,
  input  logic                ukey_en_i,
  input  logic                skey_en_i,
  input  logic [RIGHTS_W-1:0] ukey_rights_i,
  input  logic [RIGHTS_W-1:0] skey_rights_i,
  output logic [PRM_BITS-1:0] key_perm_o
);
  logic [RIGHTS_W-1:0] rights;
  logic [1:0]          pair;

  always_comb begin
    if (pg_user_i) rights = ukey_en_i ? ukey_rights_i : '0;
    else           rights = skey_en_i ? skey_rights_i : '0;
    pair       = rights[{key_i, 1'b0} +: 2];
    key_perm_o = '1;
    if (rights != '0) begin
      if (pair[0]) begin
        key_perm_o[PRM_R] = 1'b0;
        key_perm_o[PRM_W] = 1'b0;
      end else if (pair[1] && (user_i || wp_i)) begin
        key_perm_o[PRM_W] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkc_err_build.sv
module pkc_err_build
  import pkc_pkg::*;
(
  input  fault_e             kind_i,
  input  logic               user_i,
  input  logic [1:0]         acc_i,
  input  logic               nxe_i,
  input  logic               smep_i,
  output logic [EC_BITS-1:0] err_o
);
  always_comb begin
    err_o = '0;
    if (kind_i != FK_NONE) begin
      err_o[EC_P]    = (kind_i == FK_PROT) || (kind_i == FK_KEY);
      err_o[EC_PK]   = (kind_i == FK_KEY);
      err_o[EC_RSVD] = (kind_i == FK_RSVD);
      err_o[EC_U]    = user_i;
      err_o[EC_W]    = (acc_i == ACC_STORE);
      err_o[EC_ID]   = (acc_i == ACC_FETCH) && (nxe_i || smep_i);
    end
  end
endmodule

// File: rtl/pkey_perm_check.sv
module pkey_perm_check
  import pkc_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                user_mode_i,
  input  logic [1:0]          acc_type_i,
  input  logic                leaf_present_i,
  input  logic                leaf_rsvd_i,
  input  logic                leaf_user_i,
  input  logic                leaf_write_i,
  input  logic                leaf_nx_i,
  input  logic [KEY_W-1:0]    leaf_key_i,
  input  logic                wp_i,
  input  logic                smap_i,
  input  logic                smep_i,
  input  logic                nxe_i,
  input  logic                ukey_en_i,
  input  logic                skey_en_i,
  input  logic [RIGHTS_W-1:0] ukey_rights_i,
  input  logic [RIGHTS_W-1:0] skey_rights_i,
  output logic                valid_o,
  output logic [PRM_BITS-1:0] perm_o,
  output logic                fault_o,
  output logic [EC_BITS-1:0]  err_code_o
);
  logic [PRM_BITS-1:0] base_perm, key_perm, req_mask, perm_n;
  logic [EC_BITS-1:0]  err_n;
  fault_e              kind;

  pkc_base_perm u_base (
    .user_i     (user_mode_i),
    .pg_user_i  (leaf_user_i),
    .pg_write_i (leaf_write_i),
    .pg_nx_i    (leaf_nx_i),
    .wp_i       (wp_i),
    .smap_i     (smap_i),
    .smep_i     (smep_i),
    .perm_o     (base_perm)
  );

  pkc_key_gate #(.KEY_W(KEY_W)) u_key (
    .user_i        (user_mode_i),
    .pg_user_i     (leaf_user_i),
    .key_i         (leaf_key_i),
    .wp_i          (wp_i),
    .ukey_en_i     (ukey_en_i),
    .skey_en_i     (skey_en_i),
    .ukey_rights_i (ukey_rights_i),
    .skey_rights_i (skey_rights_i),
    .key_perm_o    (key_perm)
  );

  // priority: absent, reserved, user-on-supervisor, key, base
  always_comb begin
    req_mask = PRM_BITS'(3'b001 << acc_type_i);
    perm_n   = '0;
    kind     = FK_NONE;
    if (!leaf_present_i)                                kind = FK_ABSENT;
    else if (leaf_rsvd_i)                               kind = FK_RSVD;
    else if (user_mode_i && !leaf_user_i)               kind = FK_PROT;
    else if ((key_perm & req_mask) == '0)               kind = FK_KEY;
    else if ((base_perm & key_perm & req_mask) == '0)   kind = FK_PROT;
    else                                                perm_n = base_perm & key_perm;
  end

  pkc_err_build u_err (
    .kind_i (kind),
    .user_i (user_mode_i),
    .acc_i  (acc_type_i),
    .nxe_i  (nxe_i),
    .smep_i (smep_i),
    .err_o  (err_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      perm_o     <= '0;
      fault_o    <= 1'b0;
      err_code_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        perm_o     <= perm_n;
        fault_o    <= (kind != FK_NONE);
        err_code_o <= err_n;
      end
    end
  end

  p_hold_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(perm_o) && $stable(err_code_o) && $stable(fault_o)));

  p_absent_no_p_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !leaf_present_i) |=> (fault_o && !err_code_o[EC_P]));

  p_write_needs_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !fault_o && perm_o[PRM_W]) |-> perm_o[PRM_R]);

  p_key_not_fetch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_type_i == ACC_FETCH) |=> !err_code_o[EC_PK]);

  p_key_sets_p_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_code_o[EC_PK]) |-> err_code_o[EC_P]);

  p_grant_covers_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_type_i != 2'd3) |=>
      (fault_o || (perm_o[$past(acc_type_i)] && err_code_o == '0)));

  p_fault_no_perm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o) |-> (perm_o == '0 && err_code_o != '0 || perm_o == '0));
endmodule

// File: tb/pkey_perm_check_bench.sv
module pkey_perm_check_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        v_in, um, lp, lr, lu, lw, lnx, wp, smap, smep, nxe, uke, ske;
  logic [1:0]  at;
  logic [3:0]  key;
  logic [31:0] ur, sr;
  logic        v_out, f_out;
  logic [2:0]  p_out;
  logic [5:0]  e_out;

  int          n_chk = 0;
  int          n_bad = 0;
  logic        x_valid;
  logic        x_fault;
  logic [2:0]  x_perm;
  logic [5:0]  x_err;
  string       x_tag;

  always #5 clk = ~clk;

  pkey_perm_check u_pkey_perm_check (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v_in), .user_mode_i(um), .acc_type_i(at),
    .leaf_present_i(lp), .leaf_rsvd_i(lr), .leaf_user_i(lu), .leaf_write_i(lw),
    .leaf_nx_i(lnx), .leaf_key_i(key), .wp_i(wp), .smap_i(smap), .smep_i(smep),
    .nxe_i(nxe), .ukey_en_i(uke), .skey_en_i(ske), .ukey_rights_i(ur),
    .skey_rights_i(sr), .valid_o(v_out), .perm_o(p_out), .fault_o(f_out),
    .err_code_o(e_out)
  );

  // behavioural reference: returns fault, perm, err, deciding rule tag
  task automatic model(output logic fo, output logic [2:0] po, output logic [5:0] eo,
                       output string tg);
    int r, w, x, kr, kw, rights, code;
    bit denied_key, denied;
    fo = 0; po = 0; eo = 0; code = -1; tg = "R11";
    if (!lp) begin code = 0; tg = "R2"; end
    else if (lr) begin code = 8; tg = "R3"; end
    else if (um && !lu) begin code = 1; tg = "R4"; end
    else begin
      r = (smap && !um && lu) ? 0 : 1;
      w = (r == 1 && (lw || (!um && !wp))) ? 1 : 0;
      x = (!lnx && (um || !(smep && lu))) ? 1 : 0;
      if (at == 2 && x == 0) tg = "R6";
      else if (at != 2 && !(at == 0 ? r : w)) tg = "R5";
      rights = lu ? (uke ? int'(ur) : 0) : (ske ? int'(sr) : 0);
      kr = 1; kw = 1;
      if (rights != 0) begin
        if ((rights >> (2 * key)) & 1) begin kr = 0; kw = 0; end
        else if (((rights >> (2 * key + 1)) & 1) && (um || wp)) kw = 0;
        tg = (tg == "R11") ? "R8" : tg;
      end
      denied_key = (at == 0 && kr == 0) || (at == 1 && kw == 0);
      if (denied_key) begin code = 33; tg = "R9"; end
      else begin
        r = r & kr; w = w & kw;
        denied = (at == 0) ? (r == 0) : (at == 1) ? (w == 0) : (x == 0);
        if (denied) code = 1;
        else po = {x[0], w[0], r[0]};
      end
    end
    if (code >= 0) begin
      fo = 1;
      if (um) code = code + 4;
      if (at == 1) code = code + 2;
      if (at == 2 && (nxe || smep)) code = code + 16;
      eo = code[5:0];
    end
  endtask

  task automatic compare();
    n_chk++;
    if (v_out !== x_valid || p_out !== x_perm || f_out !== x_fault || e_out !== x_err) begin
      n_bad++;
      $display("FAIL %s: got v=%b p=%b f=%b e=%h exp v=%b p=%b f=%b e=%h",
               x_tag, v_out, p_out, f_out, e_out, x_valid, x_perm, x_fault, x_err);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic apply(input string tg);
    string t;
    v_in = 1;
    model(x_fault, x_perm, x_err, t);
    x_valid = 1;
    x_tag = (tg == "") ? t : tg;
    tick();
  endtask

  task automatic idle();
    v_in = 0;
    x_valid = 0;
    x_tag = "R1";
    tick();
  endtask

  task automatic clear();
    um = 0; at = 0; lp = 1; lr = 0; lu = 0; lw = 0; lnx = 0; key = 0;
    wp = 0; smap = 0; smep = 0; nxe = 0; uke = 0; ske = 0; ur = 0; sr = 0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear();
    rst_n = 0; v_in = 0;
    x_valid = 0; x_fault = 0; x_perm = 0; x_err = 0; x_tag = "R1";
    repeat (2) @(negedge clk);
    compare(); // R1 reset state
    rst_n = 1;
    idle();

    // R2 not present
    clear(); lp = 0; um = 1; at = 1; apply("R2");
    clear(); lp = 0; at = 2; nxe = 1; apply("R2");
    // R3 reserved
    clear(); lr = 1; apply("R3");
    // R4 user access to supervisor page
    clear(); um = 1; lw = 1; apply("R4");
    // R5 read prevention and write-protect override
    clear(); lu = 1; smap = 1; apply("R5");
    clear(); at = 1; apply("R5");
    clear(); at = 1; wp = 1; apply("R5");
    // R6 execute
    clear(); lu = 1; smep = 1; at = 2; apply("R6");
    clear(); um = 1; lu = 1; lnx = 1; at = 2; apply("R6");
    // R7 register selection
    clear(); um = 1; lu = 1; key = 3; ur = 32'h40; apply("R7");
    clear(); um = 1; lu = 1; key = 3; ur = 32'h40; uke = 1; apply("R7");
    clear(); lw = 1; key = 3; ur = 32'h40; uke = 1; apply("R7");
    clear(); lw = 1; key = 3; sr = 32'h40; ske = 1; apply("R7");
    // R8 write-disable and access-disable
    clear(); lw = 1; at = 1; key = 15; sr = 32'h8000_0000; ske = 1; apply("R8");
    clear(); lw = 1; at = 1; wp = 1; key = 15; sr = 32'h8000_0000; ske = 1; apply("R8");
    clear(); lw = 1; key = 0; sr = 32'h1; ske = 1; apply("R8");
    // R9 fetch survives access-disable
    clear(); um = 1; lu = 1; lw = 1; at = 2; key = 5; ur = 32'h400; uke = 1; apply("R9");
    // collision: key write-disable and read-only page
    clear(); um = 1; lu = 1; at = 1; key = 2; ur = 32'h20; uke = 1; apply("R9");
    // R10 fetch fault without I/D
    clear(); lnx = 1; at = 2; apply("R10");
    clear(); lnx = 1; at = 2; smep = 1; apply("R10");
    // R11 grant vector
    clear(); um = 1; lu = 1; lw = 1; at = 1; apply("R11");
    idle();
    idle();

    for (int i = 0; i < 3000; i++) begin
      um = $urandom; at = 2'($urandom_range(0, 2)); lp = ($urandom_range(0, 9) != 0);
      lr = ($urandom_range(0, 9) == 0); lu = $urandom; lw = $urandom; lnx = $urandom;
      key = 4'($urandom); wp = $urandom; smap = $urandom; smep = $urandom;
      nxe = $urandom; uke = $urandom; ske = $urandom;
      ur = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      sr = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      if ($urandom_range(0, 4) == 0) idle();
      else apply("");
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule